// File: doc/BRIEF.md
# Frame-synchronised serial character transmitter

This block turns bytes into asynchronous 8-N-1 serial characters. It does not use a start-on-write UART state machine. It behaves like a clocked serial-word engine. Each byte popped from a small transmit queue is wrapped into an 11-bit word. The word is shifted out least significant bit first, one bit per bit period. A word can only begin on a free-running internal frame pulse. That pulse repeats every 13 bit periods, so two idle-high bit periods always separate back-to-back characters.

Software fills the queue while the transmitter is off, then raises the enable. A fixed start-up delay of three bit periods passes before the engine is ready. The first frame pulse comes 13 bit periods after that. Status outputs report:
- a full queue;
- an empty queue, which may be reported while the last word is still on the line;
- a fully idle transmitter, which shows when the enable may be dropped without cutting a character short.

Two sticky error flags record a write to a full queue and a frame pulse that found nothing to send. Each flag is cleared by pulsing its clear input.

Top module: `fsync_uart_tx`

## Requirements
- R1: Each character is an 11-bit word sent LSB first. Word bit 0 is a high pad bit and bit 1 is a low start bit. Bits 2..9 carry the data byte, LSB first, and bit 10 is a high stop bit. Each bit lasts 2*(clk_div+1) clock cycles.
- R2: Frame pulses repeat every 13 bit periods. Each pulse that finds the queue non-empty pops one byte and starts its word, so consecutive pad bits are exactly 13 bit periods apart. The line stays high in the two bit periods after each stop bit.
- R3: The first rising edge that samples tx_enable high is counted as edge 0, and P is the bit period. The engine becomes ready after 3 bit ticks, and the first frame pulse comes 13 ticks later. The pad bit is driven from edge 16P-1, and the start bit from edge 17P-1.
- R4: The queue holds 8 bytes. fifo_full is high while 8 are held. A write while full is discarded and sets ovf_flag on the next edge.
- R5: hold_empty is high whenever the queue holds no byte, including while the last popped word is still shifting.
- R6: shift_idle is high only when the queue is empty and no word is shifting. It rises in the bit period after the stop bit of the last word.
- R7: udf_flag is set by a frame pulse that finds the queue empty while enabled, and stays set.
- R8: Pulsing clr_ovf or clr_udf high for one cycle clears the matching flag. If a new setting event occurs in the same cycle, the flag stays set.
- R9: While tx_enable is low, txd is high in the same cycle. Dropping the enable in the middle of a character abandons that word, and shift_idle reflects the abandoned word on the next edge. Bytes still in the queue are kept.
- R10: After reset: txd=1, hold_empty=1, shift_idle=1, fifo_full=0, ovf_flag=0, udf_flag=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to enqueue |
| tx_enable | input | 1 | Transmitter enable |
| clk_div | input | 16 | Bit-clock divider; bit period is 2*(clk_div+1) cycles |
| clr_ovf | input | 1 | Write-one clear of ovf_flag |
| clr_udf | input | 1 | Write-one clear of udf_flag |
| txd | output | 1 | Serial data line |
| fifo_full | output | 1 | Queue holds 8 bytes |
| hold_empty | output | 1 | Queue is empty |
| shift_idle | output | 1 | Queue empty and no word shifting |
| ovf_flag | output | 1 | Sticky write-while-full flag |
| udf_flag | output | 1 | Sticky frame-pulse-with-empty-queue flag |

## Verification
The properties assume that clk_div is held steady while the transmitter is enabled. They also assume that the clear pulses arrive as clean single-cycle strobes in step with the clock.

The stimulus respects both assumptions:
- it changes the divider only during reset, with the enable low;
- it drives every input on the falling clock edge.

Each run preloads the queue before enabling and then compares txd and the status outputs every cycle against a waveform computed from the bit-period and frame-period arithmetic. The runs sweep three divider settings and one, three and eight queued bytes, plus a ninth write to a full queue.

// File: rtl/fsut_pkg.sv
package fsut_pkg;
  // Character framing: pad(1) + start(0) + data + stop(1)
  localparam int unsigned FRAME_OVERHEAD = 3;
  // Low two bits of a packed word: bit0 pad high, bit1 start low
  localparam logic [1:0] LEAD_BITS = 2'b01;
  localparam logic       STOP_BIT  = 1'b1;

  typedef enum logic [1:0] {
    ST_WAIT_READY = 2'd0,
    ST_RUN        = 2'd1
  } fsut_phase_e;
endpackage

// File: rtl/fsut_bitclk.sv
module fsut_bitclk #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  // bit period = 2*(div+1) cycles -> count 0 .. 2*div+1
  assign limit  = {div_i, 1'b1};
  assign tick_o = run_i && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fsut_fifo.sv
module fsut_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage: no reset, written only on an accepted push
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end
endmodule

// File: rtl/fsut_framer.sv
module fsut_framer
  import fsut_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FS_DIV      = 12,
  parameter int unsigned READY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              q_empty_i,
  input  logic [DATA_W-1:0] q_data_i,
  output logic              pop_o,
  output logic              starve_o,
  output logic              busy_o,
  output logic              line_o
);
  localparam int unsigned WORD_W = DATA_W + FRAME_OVERHEAD;
  localparam int unsigned IDX_W  = $clog2(WORD_W);
  localparam int unsigned FS_W   = $clog2(FS_DIV + 1);
  localparam int unsigned RDY_W  = $clog2(READY_TICKS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  fsut_phase_e       phase_q, phase_d;
  logic [RDY_W-1:0]  rdy_q, rdy_d;
  logic [FS_W-1:0]   fs_q, fs_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              busy_q, busy_d;
  logic              fsync;
  logic [WORD_W-1:0] packed_word;

  assign packed_word = {STOP_BIT, q_data_i, LEAD_BITS};
  assign fsync    = en_i && tick_i && (phase_q == ST_RUN) && (fs_q == FS_W'(FS_DIV));
  assign pop_o    = fsync && !q_empty_i;
  assign starve_o = fsync && q_empty_i;
  assign busy_o   = busy_q;
  assign line_o   = (en_i && busy_q) ? sreg_q[0] : 1'b1;

  always_comb begin
    phase_d = phase_q;
    rdy_d   = rdy_q;
    fs_d    = fs_q;
    sreg_d  = sreg_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    if (!en_i) begin
      phase_d = ST_WAIT_READY;
      rdy_d   = '0;
      fs_d    = '0;
      busy_d  = 1'b0;
      idx_d   = '0;
    end else if (tick_i) begin
      if (phase_q == ST_WAIT_READY) begin
        rdy_d = rdy_q + 1'b1;
        if (rdy_q == RDY_W'(READY_TICKS - 1)) phase_d = ST_RUN;
      end else begin
        fs_d = fsync ? '0 : fs_q + 1'b1;
        if (fsync) begin
          if (!q_empty_i) begin
            sreg_d = packed_word;
            idx_d  = '0;
            busy_d = 1'b1;
          end
        end else if (busy_q) begin
          if (idx_q == IDX_LAST) begin
            busy_d = 1'b0;
          end else begin
            idx_d  = idx_q + 1'b1;
            sreg_d = {1'b1, sreg_q[WORD_W-1:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_WAIT_READY;
      rdy_q   <= '0;
      fs_q    <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rdy_q   <= rdy_d;
      fs_q    <= fs_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
    end
  end

  // datapath shift register: no reset needed, qualified by busy
  always_ff @(posedge clk) begin
    sreg_q <= sreg_d;
  end
endmodule

// File: rtl/fsync_uart_tx.sv
module fsync_uart_tx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned FS_DIV      = 12,
  parameter int unsigned READY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              clr_ovf,
  input  logic              clr_udf,
  output logic              txd,
  output logic              fifo_full,
  output logic              hold_empty,
  output logic              shift_idle,
  output logic              ovf_flag,
  output logic              udf_flag
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ni;
  logic                   tick, pop, starve, busy, q_empty, q_full;
  logic [DATA_W-1:0]      q_data;
  logic                   ovf_q, ovf_d, udf_q, udf_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_STAGES-1];

  fsut_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk    (clk),
    .rst_ni (rst_ni),
    .run_i  (tx_enable),
    .div_i  (clk_div),
    .tick_o (tick)
  );

  fsut_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .push_i  (wr_en),
    .din_i   (wr_data),
    .pop_i   (pop),
    .dout_o  (q_data),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  fsut_framer #(.DATA_W(DATA_W), .FS_DIV(FS_DIV), .READY_TICKS(READY_TICKS)) u_framer (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .en_i      (tx_enable),
    .tick_i    (tick),
    .q_empty_i (q_empty),
    .q_data_i  (q_data),
    .pop_o     (pop),
    .starve_o  (starve),
    .busy_o    (busy),
    .line_o    (txd)
  );

  always_comb begin
    ovf_d = (ovf_q && !clr_ovf) || (wr_en && q_full);
    udf_d = (udf_q && !clr_udf) || starve;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign fifo_full  = q_full;
  assign hold_empty = q_empty;
  assign shift_idle = q_empty && !busy;
  assign ovf_flag   = ovf_q;
  assign udf_flag   = udf_q;
endmodule

// File: rtl/fsut_checker.sv
module fsut_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tx_enable,
  input logic clr_ovf,
  input logic clr_udf,
  input logic txd,
  input logic fifo_full,
  input logic hold_empty,
  input logic shift_idle,
  input logic ovf_flag,
  input logic udf_flag
);
  p_line_high_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> txd);

  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full) |=> ovf_flag);

  p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(wr_en && fifo_full));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  p_udf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag && !clr_udf) |=> udf_flag);

  p_udf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udf_flag) |-> $past(tx_enable && hold_empty));

  p_idle_needs_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_idle |-> hold_empty);

  p_full_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !hold_empty);
endmodule

bind fsync_uart_tx fsut_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .tx_enable  (tx_enable),
  .clr_ovf    (clr_ovf),
  .clr_udf    (clr_udf),
  .txd        (txd),
  .fifo_full  (fifo_full),
  .hold_empty (hold_empty),
  .shift_idle (shift_idle),
  .ovf_flag   (ovf_flag),
  .udf_flag   (udf_flag)
);

// File: tb/sim_fsync_uart_tx.sv
module sim_fsync_uart_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, tx_enable, clr_ovf, clr_udf;
  logic [7:0]  wr_data;
  logic [15:0] clk_div;
  logic        txd, fifo_full, hold_empty, shift_idle, ovf_flag, udf_flag;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fsync_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .clk_div(clk_div), .clr_ovf(clr_ovf), .clr_udf(clr_udf),
    .txd(txd), .fifo_full(fifo_full), .hold_empty(hold_empty),
    .shift_idle(shift_idle), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] byte_of(input int j, input int dv);
    if (j == 0) return 8'hFF;
    if (j == 1) return 8'h00;
    return 8'((j * 73 + dv * 29 + 5) & 255);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; tx_enable = 0; clr_ovf = 0; clr_udf = 0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int dv, input int nch, input bit extra);
    int p;
    int total;
    p = 2 * (dv + 1);
    do_reset();
    clk_div = 16'(dv);
    for (int j = 0; j < nch + (extra ? 1 : 0); j++) begin
      wr_en = 1'b1;
      wr_data = (j < nch) ? byte_of(j, dv) : 8'hA5;
      @(negedge clk);
    end
    wr_en = 1'b0;
    if (extra) begin
      // R4: ninth write discarded, flag set
      chk(ovf_flag == 1'b1, "R4 ovf after write to full", ovf_flag, 1);
      chk(fifo_full == 1'b1, "R4 full with 8 held", fifo_full, 1);
      // R8: set wins over clear in the same cycle
      wr_en = 1'b1; clr_ovf = 1'b1; wr_data = 8'h3C;
      @(negedge clk);
      wr_en = 1'b0; clr_ovf = 1'b0;
      chk(ovf_flag == 1'b1, "R8 set wins over clear", ovf_flag, 1);
      clr_ovf = 1'b1;
      @(negedge clk);
      clr_ovf = 1'b0;
      chk(ovf_flag == 1'b0, "R8 ovf cleared", ovf_flag, 0);
    end
    tx_enable = 1'b1;
    total = (16 + 13 * nch + 3) * p;
    for (int i = 0; i < total; i++) begin
      int n, j, q;
      logic [10:0] w;
      logic exp_txd;
      @(posedge clk);
      @(negedge clk);
      n = (i + 1) / p;
      exp_txd = 1'b1;
      if (n >= 16) begin
        j = (n - 16) / 13;
        q = (n - 16) % 13;
        if (j < nch && q < 11) begin
          w = {1'b1, byte_of(j, dv), 2'b01};
          exp_txd = w[q];
        end
      end
      chk(txd == exp_txd, "R1 R2 R3 txd waveform", txd, exp_txd);
      chk(hold_empty == (n >= 16 + 13 * (nch - 1)), "R5 hold_empty",
          hold_empty, int'(n >= 16 + 13 * (nch - 1)));
      chk(shift_idle == (n >= 16 + 13 * (nch - 1) + 11), "R6 shift_idle",
          shift_idle, int'(n >= 16 + 13 * (nch - 1) + 11));
      chk(udf_flag == (n >= 16 + 13 * nch), "R7 udf_flag",
          udf_flag, int'(n >= 16 + 13 * nch));
      chk(fifo_full == (nch == 8 && n < 16), "R4 fifo_full",
          fifo_full, int'(nch == 8 && n < 16));
    end
    clr_udf = 1'b1;
    @(negedge clk);
    clr_udf = 1'b0;
    chk(udf_flag == 1'b0, "R8 udf cleared", udf_flag, 0);
    tx_enable = 1'b0;
    #1;
    chk(txd == 1'b1, "R9 line high when disabled", txd, 1);
  endtask

  initial begin
    do_reset();
    clk_div = 16'd0;
    // R10: reset state
    chk(txd == 1'b1, "R10 txd", txd, 1);
    chk(hold_empty == 1'b1, "R10 hold_empty", hold_empty, 1);
    chk(shift_idle == 1'b1, "R10 shift_idle", shift_idle, 1);
    chk(fifo_full == 1'b0, "R10 fifo_full", fifo_full, 0);
    chk(ovf_flag == 1'b0, "R10 ovf_flag", ovf_flag, 0);
    chk(udf_flag == 1'b0, "R10 udf_flag", udf_flag, 0);

    for (int dv = 0; dv < 3; dv++) begin
      run(dv, 1, 1'b0);
      run(dv, 3, 1'b0);
      run(dv, 8, 1'b1);
    end

    // R9: abandon a character mid-word, queue content kept
    do_reset();
    clk_div = 16'd0;
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_data = 8'h81;
    @(negedge clk);
    wr_en = 1'b0;
    tx_enable = 1'b1;
    for (int i = 0; i < 19 * 2; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(txd == 1'b0, "R9 mid-character data bit low", txd, 0);
    chk(shift_idle == 1'b0, "R9 shifting before disable", shift_idle, 0);
    tx_enable = 1'b0;
    #1;
    chk(txd == 1'b1, "R9 line high same cycle", txd, 1);
    @(negedge clk);
    chk(hold_empty == 1'b0, "R9 second byte kept", hold_empty, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(txd == 1'b1, "R9 line stays high", txd, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule